// File: doc/BRIEF.md
# Opcode-Driven SPI Command Sequencer

This block is a half-duplex SPI master that never takes direct bit-level control from the host. The host loads 14-bit command words into a command queue. The block executes them in order. A command either sets the chip-select level or moves a byte count of data over one, two or four I/O lines. A second, byte-wide queue is shared by both directions. Transmit commands draw their bytes from it, and receive commands deposit into it the bytes they collect from the bus.

Some transmit commands also turn the bus around. When their last byte has gone out, every output enable is released, so the lines are ready for a read that follows. Commands run only while the manual-mode selector holds the key value and the manual-enable input is high. The host learns that all work is done when the command-empty flag rises. SCK idles low, the output data moves while SCK is low, and the input data is captured on the SCK rising edge. Each SCK phase lasts a fixed number of system clocks.

Top module: `spi_op_seq`

## Requirements
- R1: A command word is {op[13:9], count[8:0]}. Queued commands run in order, and only while `modeSel` equals 9 and `manualEn` is 1. In any other setting the commands stay queued and nothing on the bus changes.
- R2: Op 0x00 drives `spiCsN` to 1 and op 0x01 drives it to 0. All other ops leave it unchanged, and it resets to 1.
- R3: Ops 0x08, 0x09 and 0x0A send `count` bytes taken from the data queue, MSB first. On one lane the bit is on IO[0]. On two lanes IO[1] carries the more significant bit. On four lanes IO[3] carries the most significant bit. `spiIoOe` becomes 0001, 0011 or 1111 and keeps that value after the command.
- R4: Ops 0x0C, 0x0E and 0x0F receive `count` bytes MSB first and push each one into the data queue. They sample IO[1] on one lane, IO[1:0] on two lanes and IO[3:0] on four lanes, at each SCK rising edge. `spiIoOe` is 0000.
- R5: Ops 0x10 to 0x18 transmit like R3, with the lane width set by groups of three: 0x10–0x12 use one lane, 0x13–0x15 use two and 0x16–0x18 use four. After the last byte, `spiIoOe` is 0000.
- R6: SCK resets low and idles low. Each high phase and each low phase lasts at least SCK_HALF clocks (2 by default), and enabled output lines change only while SCK is low.
- R7: `cmdEmpty` is 1 only while the command queue is empty and no command is executing.
- R8: Each queue holds 16 entries and raises its full flag at 16. A push strobe while the queue is full is ignored.
- R9: A transmit command waits with SCK low while the data queue is empty. A receive command waits with SCK low while the data queue is full. Both resume once the queue allows it.
- R10: A host pop and a received-byte push in the same cycle both take effect. The queue then holds the new byte and no longer holds the popped one.
- R11: A transfer op with count 0, or an undefined op, gives no SCK pulse and leaves the data queue untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 4 | Mode selector; the value 9 selects manual mode |
| manualEn | input | 1 | Manual-operation enable |
| cmdWord | input | 14 | Command word to push |
| cmdPush | input | 1 | Command-queue push strobe |
| cmdFull | output | 1 | Command queue full |
| cmdEmpty | output | 1 | Command queue empty and engine idle |
| dataWr | input | 8 | Transmit byte to push |
| dataPush | input | 1 | Data-queue push strobe |
| dataFull | output | 1 | Data queue full |
| dataEmpty | output | 1 | Data queue empty |
| dataRd | output | 8 | Head of the data queue |
| dataPop | input | 1 | Data-queue pop strobe |
| spiSck | output | 1 | Serial clock |
| spiCsN | output | 1 | Chip select, active low |
| spiIoOut | output | 4 | I/O line output values |
| spiIoOe | output | 4 | I/O line output enables |
| spiIoIn | input | 4 | I/O line input values |

## Verification
During a multi-byte receive, the host may pop the data queue on the same clock edge where the engine pushes a freshly received byte, since both act on the one shared queue. The bench first preloads the queue with one marker byte. It then starts a two-byte dual-lane read, counts SCK rising edges, and raises the pop strobe for exactly the clock on which SCK falls after the last beat of the first byte. The test passes only if the drain afterwards shows both received bytes, in order, with the marker gone and no extra entry.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam int OP_W  = 5;
  localparam int LEN_W = 9;
  localparam int CMD_W = OP_W + LEN_W;

  typedef enum logic [1:0] {LANE1 = 2'd0, LANE2 = 2'd1, LANE4 = 2'd2} laneT;
  typedef enum logic [1:0] {K_NOP, K_CSHI, K_CSLO, K_XFER} kindT;

  typedef struct packed {
    kindT kind;
    logic isTx;
    logic turn;
    laneT lanes;
  } opInfoT;

  // strobes from control to datapath
  typedef struct packed {
    logic csHi;
    logic csLo;
    logic setOe;
    logic clrOe;
    logic loadByte;
    logic shiftOut;
    logic shiftIn;
    logic sckHi;
    logic sckLo;
    logic pushRx;
    laneT lanes;
  } strobeT;

  function automatic opInfoT decodeOp(input logic [OP_W-1:0] op);
    opInfoT d;
    d.kind  = K_NOP;
    d.isTx  = 1'b0;
    d.turn  = 1'b0;
    d.lanes = LANE1;
    case (op)
      5'h00: d.kind = K_CSHI;
      5'h01: d.kind = K_CSLO;
      5'h08, 5'h09, 5'h0A: begin
        d.kind  = K_XFER;
        d.isTx  = 1'b1;
        d.lanes = (op == 5'h08) ? LANE1 : (op == 5'h09) ? LANE2 : LANE4;
      end
      5'h0C, 5'h0E, 5'h0F: begin
        d.kind  = K_XFER;
        d.lanes = (op == 5'h0C) ? LANE1 : (op == 5'h0E) ? LANE2 : LANE4;
      end
      5'h10, 5'h11, 5'h12, 5'h13, 5'h14, 5'h15, 5'h16, 5'h17, 5'h18: begin
        d.kind  = K_XFER;
        d.isTx  = 1'b1;
        d.turn  = 1'b1;
        d.lanes = (op < 5'h13) ? LANE1 : (op < 5'h16) ? LANE2 : LANE4;
      end
      default: d.kind = K_NOP;
    endcase
    return d;
  endfunction

  function automatic logic [3:0] laneMask(input laneT l);
    case (l)
      LANE1:   return 4'b0001;
      LANE2:   return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [2:0] finalBeat(input laneT l);
    case (l)
      LANE1:   return 3'd7;
      LANE2:   return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int SCK_HALF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdWord,
  input  logic             dataAvail,
  input  logic             dataRoom,
  output logic             cmdPop,
  output logic             busy,
  output strobeT           stb
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_LOW, ST_HIGH} stateT;
  localparam int TMR_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [TMR_W-1:0] TMR_END = TMR_W'(SCK_HALF - 1);

  stateT            state, stateNxt;
  logic [TMR_W-1:0] tmr, tmrNxt;
  logic [2:0]       beat, beatNxt;
  logic [LEN_W-1:0] remain, remainNxt;
  logic             curTx, curTxNxt, curTurn, curTurnNxt;
  laneT             curLanes, curLanesNxt;
  opInfoT           info;
  logic [LEN_W-1:0] cmdLen;
  logic             tmrDone, lastBeat;

  assign info     = decodeOp(cmdWord[CMD_W-1 -: OP_W]);
  assign cmdLen   = cmdWord[LEN_W-1:0];
  assign tmrDone  = (tmr == TMR_END);
  assign lastBeat = (beat == finalBeat(curLanes));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stateNxt    = state;
    tmrNxt      = tmr;
    beatNxt     = beat;
    remainNxt   = remain;
    curTxNxt    = curTx;
    curTurnNxt  = curTurn;
    curLanesNxt = curLanes;
    cmdPop      = 1'b0;
    stb         = '0;
    stb.lanes   = curLanes;
    case (state)
      ST_IDLE: begin
        if (runEn && cmdValid) begin
          cmdPop = 1'b1;
          case (info.kind)
            K_CSHI: stb.csHi = 1'b1;
            K_CSLO: stb.csLo = 1'b1;
            K_XFER: begin
              if (cmdLen != '0) begin
                curTxNxt    = info.isTx;
                curTurnNxt  = info.turn;
                curLanesNxt = info.lanes;
                remainNxt   = cmdLen;
                stb.lanes   = info.lanes;
                stb.setOe   = info.isTx;
                stb.clrOe   = !info.isTx;
                stateNxt    = ST_LOAD;
              end
            end
            default: ;
          endcase
        end
      end
      ST_LOAD: begin
        if (curTx ? dataAvail : dataRoom) begin
          stb.loadByte = curTx;
          tmrNxt       = '0;
          beatNxt      = '0;
          stateNxt     = ST_LOW;
        end
      end
      ST_LOW: begin
        if (tmrDone) begin
          tmrNxt      = '0;
          stb.sckHi   = 1'b1;
          stb.shiftIn = !curTx;
          stateNxt    = ST_HIGH;
        end else begin
          tmrNxt = tmr + 1'b1;
        end
      end
      ST_HIGH: begin
        if (tmrDone) begin
          tmrNxt    = '0;
          stb.sckLo = 1'b1;
          if (lastBeat) begin
            stb.pushRx = !curTx;
            remainNxt  = remain - 1'b1;
            if (remain == LEN_W'(1)) begin
              stb.clrOe = curTurn;
              stateNxt  = ST_IDLE;
            end else begin
              stateNxt = ST_LOAD;
            end
          end else begin
            stb.shiftOut = curTx;
            beatNxt      = beat + 1'b1;
            stateNxt     = ST_LOW;
          end
        end else begin
          tmrNxt = tmr + 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      beat     <= '0;
      remain   <= '0;
      curTx    <= 1'b0;
      curTurn  <= 1'b0;
      curLanes <= LANE1;
    end else begin
      state    <= stateNxt;
      tmr      <= tmrNxt;
      beat     <= beatNxt;
      remain   <= remainNxt;
      curTx    <= curTxNxt;
      curTurn  <= curTurnNxt;
      curLanes <= curLanesNxt;
    end
  end
endmodule

// File: rtl/spi_seq_dp.sv
module spi_seq_dp
  import spi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     stb,
  input  logic [7:0] txByte,
  input  logic [3:0] ioIn,
  output logic       sck,
  output logic       csN,
  output logic [3:0] ioOut,
  output logic [3:0] ioOe,
  output logic [7:0] rxByte
);
  logic [7:0] shReg, shInVal, shOutVal;

  always_comb begin
    case (stb.lanes)
      LANE1: begin
        ioOut    = {3'b000, shReg[7]};
        shInVal  = {shReg[6:0], ioIn[1]};
        shOutVal = {shReg[6:0], 1'b0};
      end
      LANE2: begin
        ioOut    = {2'b00, shReg[7:6]};
        shInVal  = {shReg[5:0], ioIn[1:0]};
        shOutVal = {shReg[5:0], 2'b00};
      end
      default: begin
        ioOut    = shReg[7:4];
        shInVal  = {shReg[3:0], ioIn[3:0]};
        shOutVal = {shReg[3:0], 4'b0000};
      end
    endcase
  end

  assign rxByte = shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sck   <= 1'b0;
      csN   <= 1'b1;
      ioOe  <= 4'b0000;
      shReg <= 8'h00;
    end else begin
      if (stb.sckHi)      sck <= 1'b1;
      else if (stb.sckLo) sck <= 1'b0;
      if (stb.csHi)       csN <= 1'b1;
      else if (stb.csLo)  csN <= 1'b0;
      if (stb.setOe)      ioOe <= laneMask(stb.lanes);
      else if (stb.clrOe) ioOe <= 4'b0000;
      if (stb.loadByte)      shReg <= txByte;
      else if (stb.shiftIn)  shReg <= shInVal;
      else if (stb.shiftOut) shReg <= shOutVal;
    end
  end
endmodule

// File: rtl/spi_op_seq.sv
module spi_op_seq
  import spi_seq_pkg::*;
#(
  parameter int CMD_DEPTH  = 16,
  parameter int DATA_DEPTH = 16,
  parameter int SCK_HALF   = 2,
  parameter int MANUAL_KEY = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       modeSel,
  input  logic             manualEn,
  input  logic [CMD_W-1:0] cmdWord,
  input  logic             cmdPush,
  output logic             cmdFull,
  output logic             cmdEmpty,
  input  logic [7:0]       dataWr,
  input  logic             dataPush,
  output logic             dataFull,
  output logic             dataEmpty,
  output logic [7:0]       dataRd,
  input  logic             dataPop,
  output logic             spiSck,
  output logic             spiCsN,
  output logic [3:0]       spiIoOut,
  output logic [3:0]       spiIoOe,
  input  logic [3:0]       spiIoIn
);
  logic             runEn, cmdQEmpty, cmdPop, busy;
  logic [CMD_W-1:0] cmdHead;
  strobeT           stb;
  logic [7:0]       rxByte, dataIn;
  logic             dPush, dPop;

  assign runEn    = manualEn && (modeSel == 4'(MANUAL_KEY));
  assign cmdEmpty = cmdQEmpty && !busy;
  // engine push has priority over a host push
  assign dPush    = stb.pushRx || (dataPush && !dataFull);
  assign dataIn   = stb.pushRx ? rxByte : dataWr;
  assign dPop     = stb.loadByte || dataPop;

  spi_seq_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) cmdQ_i (
    .clk(clk), .rstN(rstN), .push(cmdPush), .wdata(cmdWord),
    .pop(cmdPop), .rdata(cmdHead), .full(cmdFull), .empty(cmdQEmpty)
  );

  spi_seq_fifo #(.W(8), .DEPTH(DATA_DEPTH)) dataQ_i (
    .clk(clk), .rstN(rstN), .push(dPush), .wdata(dataIn),
    .pop(dPop), .rdata(dataRd), .full(dataFull), .empty(dataEmpty)
  );

  spi_seq_ctrl #(.SCK_HALF(SCK_HALF)) ctrl_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cmdValid(!cmdQEmpty),
    .cmdWord(cmdHead), .dataAvail(!dataEmpty), .dataRoom(!dataFull),
    .cmdPop(cmdPop), .busy(busy), .stb(stb)
  );

  spi_seq_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .txByte(dataRd), .ioIn(spiIoIn),
    .sck(spiSck), .csN(spiCsN), .ioOut(spiIoOut), .ioOe(spiIoOe), .rxByte(rxByte)
  );
endmodule

// File: rtl/spi_op_seq_chk.sv
module spi_op_seq_chk #(
  parameter int SCK_HALF = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       spiSck,
  input logic       spiCsN,
  input logic [3:0] spiIoOut,
  input logic [3:0] spiIoOe,
  input logic       cmdEmpty
);
  // R6
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdEmpty |-> !spiSck);

  // R6
  drive_while_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spiIoOut & spiIoOe) |-> !spiSck);

  // R6
  oe_while_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spiIoOe) |-> !spiSck);

  // R2
  cs_quiet_sck_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spiCsN) |-> (!spiSck && !$past(spiSck)));

  // R7
  cs_hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEmpty && $past(cmdEmpty)) |-> $stable(spiCsN));

  // R6
  high_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (SCK_HALF > 1 && $rose(spiSck)) |=> spiSck);

  // R6
  low_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (SCK_HALF > 1 && $fell(spiSck)) |=> !spiSck);
endmodule

bind spi_op_seq spi_op_seq_chk #(.SCK_HALF(SCK_HALF)) chk_i (
  .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN),
  .spiIoOut(spiIoOut), .spiIoOe(spiIoOe), .cmdEmpty(cmdEmpty)
);

// File: tb/spi_op_seq_tb_top.sv
`timescale 1ns/1ps
module spi_op_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  modeSel = 4'd0;
  logic        manualEn = 1'b0;
  logic [13:0] cmdWord = '0;
  logic        cmdPush = 1'b0;
  logic        cmdFull, cmdEmpty;
  logic [7:0]  dataWr = '0;
  logic        dataPush = 1'b0;
  logic        dataFull, dataEmpty;
  logic [7:0]  dataRd;
  logic        dataPop = 1'b0;
  logic        spiSck, spiCsN;
  logic [3:0]  spiIoOut, spiIoOe, spiIoIn;

  int          tests = 0;
  int          fails = 0;
  int          riseCnt = 0;
  int          slvBase = 0;
  int          slvLanes = 1;
  int          capLanes = 1;
  logic [31:0] slvStream = '0;
  logic [31:0] capReg = '0;

  // op[23:19] byte[18:11] lanes[10:8] oe[7:4]
  localparam logic [23:0] VECS [8] = '{
    {5'h08, 8'hA5, 3'd1, 4'b0001, 4'h0},
    {5'h09, 8'h3C, 3'd2, 4'b0011, 4'h0},
    {5'h0A, 8'hE7, 3'd4, 4'b1111, 4'h0},
    {5'h10, 8'h5A, 3'd1, 4'b0000, 4'h0},
    {5'h13, 8'hC3, 3'd2, 4'b0000, 4'h0},
    {5'h16, 8'h96, 3'd4, 4'b0000, 4'h0},
    {5'h12, 8'h81, 3'd1, 4'b0000, 4'h0},
    {5'h18, 8'h4B, 3'd4, 4'b0000, 4'h0}
  };

  always #2 clk = ~clk;

  spi_op_seq dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .manualEn(manualEn),
    .cmdWord(cmdWord), .cmdPush(cmdPush), .cmdFull(cmdFull), .cmdEmpty(cmdEmpty),
    .dataWr(dataWr), .dataPush(dataPush), .dataFull(dataFull), .dataEmpty(dataEmpty),
    .dataRd(dataRd), .dataPop(dataPop), .spiSck(spiSck), .spiCsN(spiCsN),
    .spiIoOut(spiIoOut), .spiIoOe(spiIoOe), .spiIoIn(spiIoIn)
  );

  function automatic logic [3:0] slvBits(input int cnt, input int lanes, input logic [31:0] stream);
    int beats, bi, ci;
    logic [7:0] b, v;
    beats = 8 / lanes;
    bi = cnt / beats;
    ci = cnt % beats;
    if (bi > 3 || cnt < 0) return 4'b0000;
    b = 8'(stream >> (24 - 8 * bi));
    v = b >> (8 - lanes * (ci + 1));
    if (lanes == 1) return {2'b00, v[0], 1'b0};
    if (lanes == 2) return {2'b00, v[1:0]};
    return v[3:0];
  endfunction

  assign spiIoIn = slvBits(riseCnt - slvBase, slvLanes, slvStream);

  always @(posedge spiSck) begin
    riseCnt <= riseCnt + 1;
    case (capLanes)
      1:       capReg <= {capReg[30:0], spiIoOut[0]};
      2:       capReg <= {capReg[29:0], spiIoOut[1:0]};
      default: capReg <= {capReg[27:0], spiIoOut[3:0]};
    endcase
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushCmd(input logic [4:0] op, input int cnt);
    @(negedge clk);
    cmdWord = {op, 9'(cnt)};
    cmdPush = 1'b1;
    @(negedge clk);
    cmdPush = 1'b0;
  endtask

  task automatic pushData(input logic [7:0] b);
    @(negedge clk);
    dataWr = b;
    dataPush = 1'b1;
    @(negedge clk);
    dataPush = 1'b0;
  endtask

  task automatic popData(output logic [7:0] b);
    @(negedge clk);
    b = dataRd;
    dataPop = 1'b1;
    @(negedge clk);
    dataPop = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!cmdEmpty) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=busy expected=idle");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int base, n;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R2 reset csN", 32'(spiCsN), 32'd1);
    chk("R6 reset sck", 32'(spiSck), 32'd0);
    chk("R3 reset oe", 32'(spiIoOe), 32'd0);
    chk("R7 reset cmdEmpty", 32'(cmdEmpty), 32'd1);
    chk("R8 reset dataEmpty/full", {30'd0, dataEmpty, dataFull}, 32'd2);

    // R1: manual gating
    modeSel = 4'd9; manualEn = 1'b0;
    pushCmd(5'h01, 0);
    repeat (20) @(negedge clk);
    chk("R1 enable low csN", 32'(spiCsN), 32'd1);
    chk("R1 enable low cmdEmpty", 32'(cmdEmpty), 32'd0);
    modeSel = 4'd3; manualEn = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 wrong key csN", 32'(spiCsN), 32'd1);
    modeSel = 4'd9;
    waitIdle();
    chk("R2 cs low", 32'(spiCsN), 32'd0);

    // R3/R5 vector table
    for (int vi = 0; vi < 8; vi++) begin
      logic [23:0] v;
      v = VECS[vi];
      capLanes = int'(v[10:8]);
      pushData(v[18:11]);
      base = riseCnt;
      pushCmd(v[23:19], 1);
      waitIdle();
      chk(v[23:19] >= 5'h10 ? "R5 edges" : "R3 edges", 32'(riseCnt - base), 32'(8 / int'(v[10:8])));
      chk(v[23:19] >= 5'h10 ? "R5 data" : "R3 data", {24'd0, capReg[7:0]}, {24'd0, v[18:11]});
      chk(v[23:19] >= 5'h10 ? "R5 oe" : "R3 oe", 32'(spiIoOe), 32'(v[7:4]));
    end

    // R4 receive at each width
    slvStream = {8'hB4, 8'h6D, 8'h2F, 8'h00};
    for (int li = 0; li < 3; li++) begin
      logic [4:0] op;
      logic [7:0] expB;
      op = (li == 0) ? 5'h0C : (li == 1) ? 5'h0E : 5'h0F;
      slvLanes = (li == 0) ? 1 : (li == 1) ? 2 : 4;
      capLanes = slvLanes;
      slvStream = {8'(8'hB4 + 8'(li * 8'h37)), 24'd0};
      expB = 8'(8'hB4 + 8'(li * 8'h37));
      slvBase = riseCnt;
      base = riseCnt;
      pushCmd(op, 1);
      waitIdle();
      chk("R4 edges", 32'(riseCnt - base), 32'(8 / slvLanes));
      chk("R4 oe", 32'(spiIoOe), 32'd0);
      popData(b);
      chk("R4 rx byte", 32'(b), 32'(expB));
    end

    // R3 two bytes, R6 phase length, R7 busy flag
    capLanes = 1;
    pushData(8'hC5);
    pushData(8'h1E);
    base = riseCnt;
    pushCmd(5'h08, 2);
    @(posedge spiSck);
    n = 0;
    @(negedge clk);
    chk("R7 busy while shifting", 32'(cmdEmpty), 32'd0);
    while (spiSck) begin
      n++;
      @(negedge clk);
    end
    chk("R6 high phase clocks", 32'(n), 32'd2);
    waitIdle();
    chk("R3 two-byte edges", 32'(riseCnt - base), 32'd16);
    chk("R3 two-byte data", {16'd0, capReg[15:0]}, 32'h0000C51E);

    // R9 transmit stall
    capLanes = 2;
    base = riseCnt;
    pushCmd(5'h09, 1);
    repeat (30) @(negedge clk);
    chk("R9 tx stall edges", 32'(riseCnt - base), 32'd0);
    chk("R9 tx stall sck", 32'(spiSck), 32'd0);
    chk("R7 stalled not empty", 32'(cmdEmpty), 32'd0);
    pushData(8'h72);
    waitIdle();
    chk("R9 tx resume data", {24'd0, capReg[7:0]}, 32'h72);

    // R8 data full, R9 receive stall
    for (int i = 0; i < 16; i++) pushData(8'(8'h40 + i));
    @(negedge clk);
    chk("R8 data full", 32'(dataFull), 32'd1);
    pushData(8'hEE);
    slvLanes = 4; capLanes = 4;
    slvStream = {8'h99, 24'd0};
    slvBase = riseCnt;
    base = riseCnt;
    pushCmd(5'h0F, 1);
    repeat (30) @(negedge clk);
    chk("R9 rx stall edges", 32'(riseCnt - base), 32'd0);
    popData(b);
    chk("R8 head byte", 32'(b), 32'h40);
    waitIdle();
    chk("R9 rx resume edges", 32'(riseCnt - base), 32'd2);
    for (int i = 1; i < 16; i++) begin
      popData(b);
      chk("R8 drain byte", 32'(b), 32'(8'h40 + i));
    end
    popData(b);
    chk("R9 rx byte after stall", 32'(b), 32'h99);
    chk("R8 drained empty", 32'(dataEmpty), 32'd1);

    // R10 host pop and engine push in the same cycle
    pushData(8'h11);
    slvLanes = 2; capLanes = 2;
    slvStream = {8'h3A, 8'hD2, 16'd0};
    slvBase = riseCnt;
    base = riseCnt;
    pushCmd(5'h0E, 2);
    while ((riseCnt - base) < 4) @(negedge clk);
    @(negedge clk);
    chk("R10 marker still head", 32'(dataRd), 32'h11);
    dataPop = 1'b1;
    @(negedge clk);
    dataPop = 1'b0;
    waitIdle();
    popData(b);
    chk("R10 first rx byte", 32'(b), 32'h3A);
    popData(b);
    chk("R10 second rx byte", 32'(b), 32'hD2);
    chk("R10 queue empty", 32'(dataEmpty), 32'd1);

    // R11 zero count and undefined op
    pushData(8'h5E);
    base = riseCnt;
    pushCmd(5'h08, 0);
    pushCmd(5'h05, 3);
    waitIdle();
    repeat (4) @(negedge clk);
    chk("R11 no edges", 32'(riseCnt - base), 32'd0);
    popData(b);
    chk("R11 data untouched", 32'(b), 32'h5E);

    // R8 command queue full
    manualEn = 1'b0;
    for (int i = 0; i < 15; i++) pushCmd(5'h00, 0);
    pushCmd(5'h01, 0);
    chk("R8 cmd full", 32'(cmdFull), 32'd1);
    pushCmd(5'h00, 0);
    manualEn = 1'b1;
    waitIdle();
    chk("R8 extra cmd dropped", 32'(spiCsN), 32'd0);
    pushCmd(5'h00, 0);
    waitIdle();
    chk("R2 cs high", 32'(spiCsN), 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule